// File: doc/BRIEF.md
# Sample Playback Voice Sequencer

This block is a single voice of a multichannel sample player. From a programmed start address it walks a byte offset through external memory. The pace is set by a rate divider applied to a reference enable. At each rate tick it reads one or two bytes over a request/acknowledge handshake and assembles them into a signed 16-bit sample, which it holds on its output until the next sample is ready.

Playback follows a gate in the style of an envelope. A rising gate restarts the sample. With looping enabled, the voice cycles between two loop points while the gate stays high. Once the gate falls, the voice plays on to the programmed length. With looping disabled, a falling gate silences the voice at once. An interleave option doubles the address step, so that two voices can split stereo data. When the last byte is consumed, the voice stops, outputs zero and pulses an end flag for one cycle.

The memory controller, the mixer and the host register decoding sit outside this block. All configuration inputs are read live on every cycle.

Top module: `smp_voice`

## Requirements
- R1: While `rst_n` is low, and after it is released, `mem_req` is 0, `smp_out` is 0 and `end_pulse` is 0 until the gate rises.
- R2: A cycle in which `cfg_gate` is 1 and was 0 in the previous cycle restarts the voice. The offset becomes 0, the rate count clears and `smp_out` becomes 0. The first request after a restart is to address `cfg_start`.
- R3: After a restart, the voice counts `ref_en` pulses. The pulse that finds the count at or above `cfg_div`-1 is a tick (a divider of 0 acts as 1), and the count then clears. A tick seen while waiting raises `mem_req` on the next cycle. A tick during a fetch is lost. A changed divider applies at the next comparison, without a restart.
- R4: Mode 2'b00 is 8-bit: one byte is fetched at `cfg_start`+offset, and `smp_out` becomes {byte, 8'h00}. The base step is 1.
- R5: Mode 2'b01 is 16-bit little-endian: the byte at the lower address is the low half and the next byte is the high half. The base step is 2. An odd length never ends 16-bit playback.
- R6: Modes 2'b10 and 2'b11 fetch and step like 8-bit, but every completed sample drives `smp_out` to 0.
- R7: With `cfg_il` set, the step after each sample is twice the base step.
- R8: When the advanced offset equals `cfg_len` (and no loop jump applies), the voice stops. On the next cycle `smp_out` is 0 and `end_pulse` is 1 for exactly one cycle. No further requests are made.
- R9: With `cfg_loop` and `cfg_gate` both 1, an advanced offset equal to `cfg_pb` is replaced by `cfg_pa`. This check takes priority over the length check.
- R10: With `cfg_loop` set and the gate low, point B is ignored and playback runs to `cfg_len`, then ends as in R8.
- R11: With `cfg_loop` 0 and the gate low, the voice stops on the next edge without an end pulse. A pending request is withdrawn and `smp_out` becomes 0.
- R12: While the gate stays high and no acknowledge arrives, `mem_req` stays high and `mem_addr` holds steady. `mem_data` is taken in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_en | input | 1 | Rate reference enable (one pulse per reference period) |
| cfg_gate | input | 1 | Gate: rise restarts, fall releases or stops |
| cfg_loop | input | 1 | Loop between points A and B while gated |
| cfg_il | input | 1 | Interleave: double address step |
| cfg_mode | input | 2 | Sample format (00 8-bit, 01 16-bit LE, others silent) |
| cfg_start | input | ADDR_W | Sample start address |
| cfg_len | input | LEN_W | Sample length in bytes |
| cfg_div | input | DIV_W | Rate divider |
| cfg_pa | input | LEN_W | Loop return offset A |
| cfg_pb | input | LEN_W | Loop trigger offset B |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_data | input | 8 | Read data byte |
| smp_out | output | 16 | Signed sample output |
| end_pulse | output | 1 | One-cycle pulse at end of sample |

## Verification
The bench builds the voice with its default widths: a 32-bit address, a 24-bit length and a 16-bit divider. It programs dividers of 1 to 8 and lengths of a few dozen bytes, so that every end, loop jump and gate release falls within a few hundred cycles. The bench varies the acknowledge latency from 0 to 3 cycles and gates `ref_en` on alternate cycles. This puts ticks lost during fetches, divider changes in mid-play and withdrawn requests within reach, alongside the long-running odd-length 16-bit case.

// File: rtl/smpv_pkg.sv
`timescale 1ns/1ps
package smpv_pkg;
  typedef enum logic [1:0] {PH_WAIT = 2'd0, PH_LO = 2'd1, PH_HI = 2'd2} phase_t;
  localparam logic [1:0] MODE_PCM8  = 2'b00;
  localparam logic [1:0] MODE_PCM16 = 2'b01;
endpackage

// File: rtl/smpv_rate.sv
`timescale 1ns/1ps
module smpv_rate #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  // divider of zero behaves as one
  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = ref_en && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (ref_en) cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smpv_seq.sv
`timescale 1ns/1ps
module smpv_seq
  import smpv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              loop_en,
  input  logic              il_en,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  pa,
  input  logic [LEN_W-1:0]  pb,
  input  logic              tick,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              lo_we,
  output logic              fin_we,
  output logic              zero_out,
  output logic              restart,
  output logic              running,
  output logic              end_pulse
);
  phase_t           ph_q, ph_d;
  logic             run_q, run_d, gate_q, end_q, end_d;
  logic [LEN_W-1:0] off_q, off_d, width_b, step, adv;
  logic             halt;

  assign restart  = gate && !gate_q;
  assign halt     = run_q && !gate && !loop_en;
  assign width_b  = (mode == MODE_PCM16) ? LEN_W'(2) : LEN_W'(1);
  assign step     = il_en ? (width_b << 1) : width_b;
  assign adv      = off_q + step;
  assign mem_req  = run_q && (ph_q != PH_WAIT);
  assign mem_addr = start + ADDR_W'(off_q) + ADDR_W'(ph_q == PH_HI);
  assign running  = run_q;
  assign end_pulse = end_q;

  always_comb begin
    ph_d     = ph_q;
    run_d    = run_q;
    off_d    = off_q;
    end_d    = 1'b0;
    lo_we    = 1'b0;
    fin_we   = 1'b0;
    zero_out = 1'b0;
    if (restart) begin
      run_d    = 1'b1;
      ph_d     = PH_WAIT;
      off_d    = '0;
      zero_out = 1'b1;
    end else if (halt) begin
      run_d    = 1'b0;
      ph_d     = PH_WAIT;
      zero_out = 1'b1;
    end else if (run_q) begin
      unique case (ph_q)
        PH_WAIT: if (tick) ph_d = PH_LO;
        PH_LO: if (mem_ack) begin
          lo_we = 1'b1;
          if (mode == MODE_PCM16) ph_d = PH_HI;
        end
        default: ;
      endcase
      // sample complete: single byte, or high byte of a 16-bit pair
      if (mem_ack && ((ph_q == PH_HI) || (ph_q == PH_LO && mode != MODE_PCM16))) begin
        ph_d = PH_WAIT;
        if (loop_en && gate && adv == pb) begin
          off_d  = pa;
          fin_we = 1'b1;
        end else if (adv == len) begin
          off_d    = adv;
          run_d    = 1'b0;
          end_d    = 1'b1;
          zero_out = 1'b1;
        end else begin
          off_d  = adv;
          fin_we = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_WAIT;
      run_q  <= 1'b0;
      off_q  <= '0;
      gate_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      run_q  <= run_d;
      off_q  <= off_d;
      gate_q <= gate;
      end_q  <= end_d;
    end
  end
endmodule

// File: rtl/smpv_pack.sv
`timescale 1ns/1ps
module smpv_pack
  import smpv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        zero_out,
  input  logic        lo_we,
  input  logic        fin_we,
  input  logic [1:0]  mode,
  input  logic [7:0]  data,
  output logic [15:0] smp_out
);
  logic [7:0]  lo_q;
  logic [15:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (zero_out) out_d = '0;
    else if (fin_we) begin
      unique case (mode)
        MODE_PCM8:  out_d = {data, 8'h00};
        MODE_PCM16: out_d = {data, lo_q};
        default:    out_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      out_q <= '0;
    end else begin
      if (lo_we) lo_q <= data;
      out_q <= out_d;
    end
  end

  assign smp_out = out_q;
endmodule

// File: rtl/smp_voice.sv
`timescale 1ns/1ps
module smp_voice #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              cfg_gate,
  input  logic              cfg_loop,
  input  logic              cfg_il,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_pa,
  input  logic [LEN_W-1:0]  cfg_pb,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_data,
  output logic [15:0]       smp_out,
  output logic              end_pulse
);
  logic tick, restart, running, lo_we, fin_we, zero_out;

  smpv_rate #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .clr(restart || !running),
    .ref_en(ref_en), .div(cfg_div), .tick(tick)
  );

  smpv_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .gate(cfg_gate), .loop_en(cfg_loop),
    .il_en(cfg_il), .mode(cfg_mode), .start(cfg_start), .len(cfg_len),
    .pa(cfg_pa), .pb(cfg_pb), .tick(tick), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .lo_we(lo_we), .fin_we(fin_we),
    .zero_out(zero_out), .restart(restart), .running(running),
    .end_pulse(end_pulse)
  );

  smpv_pack u_pack (
    .clk(clk), .rst_n(rst_n), .zero_out(zero_out), .lo_we(lo_we),
    .fin_we(fin_we), .mode(cfg_mode), .data(mem_data), .smp_out(smp_out)
  );
endmodule

// File: rtl/smpv_chk.sv
`timescale 1ns/1ps
module smpv_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_gate,
  input logic              cfg_loop,
  input logic [ADDR_W-1:0] cfg_start,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       smp_out,
  input logic              end_pulse
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && cfg_gate && $past(cfg_gate))
    |=> (mem_req && (!$stable(cfg_start) || $stable(mem_addr))));

  // R8
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse);

  // R8
  end_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> (smp_out == 16'h0000 && !mem_req));

  // R11
  gate_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gate && !cfg_loop) |=> (!mem_req && smp_out == 16'h0000 && !end_pulse));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_gate) |=> (!mem_req && smp_out == 16'h0000));
endmodule

bind smp_voice smpv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gate(cfg_gate), .cfg_loop(cfg_loop),
  .cfg_start(cfg_start), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .smp_out(smp_out), .end_pulse(end_pulse)
);

// File: tb/test_smp_voice.sv
`timescale 1ns/1ps
module test_smp_voice;
  logic        clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0;
  logic        cfg_gate = 0, cfg_loop = 0, cfg_il = 0;
  logic [1:0]  cfg_mode = 0;
  logic [31:0] cfg_start = 0;
  logic [23:0] cfg_len = 0, cfg_pa = 0, cfg_pb = 0;
  logic [15:0] cfg_div = 1;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data = 0;
  logic [15:0] smp_out;
  logic        end_pulse;

  smp_voice i_smp_voice (.*);

  always #4 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, ends = 0, lat = 0, ref_pat = 0, cyc = 0, wc = 0;
  string tag = "R1";
  bit    checking = 0;

  // behavioural reference state
  int        m_off, m_cnt, m_ph, lim;
  bit        m_run, m_gq, m_end, tk, rise, halt, done;
  logic [7:0]  m_lo;
  logic [15:0] m_out;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'(a * 37 + (a >> 8) + 11);
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_off = 0; m_cnt = 0; m_out = 0; m_end = 0; m_lo = 0; m_gq = 0;
    end else begin
      lim  = (cfg_div == 0) ? 0 : int'(cfg_div) - 1;
      tk   = ref_en && (m_cnt >= lim);
      rise = cfg_gate && !m_gq;
      halt = m_run && !cfg_gate && !cfg_loop;
      m_end = 0;
      if (rise || !m_run) m_cnt = 0;
      else if (ref_en) m_cnt = tk ? 0 : m_cnt + 1;
      if (rise) begin
        m_run = 1; m_ph = 0; m_off = 0; m_out = 0;
      end else if (halt) begin
        m_run = 0; m_ph = 0; m_out = 0;
      end else if (m_run) begin
        done = 0;
        if (m_ph == 0) begin
          if (tk) m_ph = 1;
        end else if (mem_ack) begin
          if (m_ph == 1 && cfg_mode == 2'b01) begin
            m_lo = mem_data; m_ph = 2;
          end else done = 1;
        end
        if (done) begin
          int w, nxt;
          logic [15:0] s;
          w   = (cfg_mode == 2'b01) ? 2 : 1;
          if (cfg_il) w = w * 2;
          nxt = m_off + w;
          s   = (cfg_mode == 2'b00) ? {mem_data, 8'h00} :
                (cfg_mode == 2'b01) ? {mem_data, m_lo} : 16'h0000;
          m_ph = 0;
          if (cfg_loop && cfg_gate && nxt == int'(cfg_pb)) begin
            m_off = int'(cfg_pa); m_out = s;
          end else if (nxt == int'(cfg_len)) begin
            m_off = nxt; m_run = 0; m_end = 1; m_out = 0;
          end else begin
            m_off = nxt; m_out = s;
          end
        end
      end
      m_gq = cfg_gate;
    end
  end

  // compare, then drive memory and reference enable
  always @(negedge clk) begin
    cyc++;
    if (checking) begin
      bit mreq;
      mreq = m_run && (m_ph != 0);
      chk(mem_req == mreq, tag, mem_req, mreq);
      if (mreq) chk(mem_addr == cfg_start + m_off + (m_ph == 2), {tag, " R12 addr"}, mem_addr, cfg_start + m_off + (m_ph == 2));
      chk(smp_out == m_out, tag, smp_out, m_out);
      chk(end_pulse == m_end, {tag, " R8"}, end_pulse, m_end);
      if (end_pulse) ends++;
    end
    if (mem_req) begin
      if (wc >= lat) begin mem_ack = 1; mem_data = mem_byte(mem_addr); wc = 0; end
      else begin mem_ack = 0; wc++; end
    end else begin
      mem_ack = 0; wc = 0; mem_data = 8'hxx & 8'h00;
    end
    ref_en = (ref_pat == 0) ? 1'b1 : cyc[0];
  end

  task automatic tick_to(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic setup(input logic [1:0] md, input bit il, input bit lp, input logic [31:0] st,
                       input int ln, input int a, input int b, input int dv);
    cfg_gate = 0; cfg_loop = 0;
    tick_to(2);
    cfg_mode = md; cfg_il = il; cfg_loop = lp; cfg_start = st;
    cfg_len = 24'(ln); cfg_pa = 24'(a); cfg_pb = 24'(b); cfg_div = 16'(dv);
    ends = 0;
    tick_to(1);
  endtask

  // raise gate and confirm first request goes to the start address
  task automatic launch(input string r);
    int k;
    cfg_gate = 1;
    k = 0;
    while (!mem_req && k < 100) begin tick_to(1); k++; end
    chk(mem_req && mem_addr == cfg_start, r, mem_addr, cfg_start);
  endtask

  initial begin
    // R1 reset state
    tick_to(3);
    chk(!mem_req && smp_out == 0 && !end_pulse, "R1 in reset", {mem_req, smp_out, end_pulse}, 0);
    rst_n = 1;
    tick_to(3);
    chk(!mem_req && smp_out == 0 && !end_pulse, "R1 after reset", {mem_req, smp_out, end_pulse}, 0);
    checking = 1;

    // R2 R3 R4 R8: 8-bit, divider 4, zero latency
    tag = "R4"; lat = 0;
    setup(2'b00, 0, 0, 32'h0100_0040, 6, 0, 0, 4);
    launch("R2 first addr");
    tick_to(80);
    chk(ends == 1, "R8 end count", ends, 1);

    // R5 R12: 16-bit with latency 2
    tag = "R5"; lat = 2;
    setup(2'b01, 0, 0, 32'h0000_1233, 8, 0, 0, 3);
    launch("R2 first addr 16b");
    tick_to(120);
    chk(ends == 1, "R5 end count", ends, 1);

    // R5 odd length never ends
    tag = "R5 odd";
    setup(2'b01, 0, 0, 32'h0000_2000, 5, 0, 0, 2);
    launch("R2 first addr odd");
    tick_to(300);
    chk(ends == 0, "R5 odd length no end", ends, 0);

    // R7 interleave
    tag = "R7"; lat = 1;
    setup(2'b00, 1, 0, 32'h0000_3001, 8, 0, 0, 2);
    launch("R7 first addr");
    tick_to(80);
    chk(ends == 1, "R7 end count", ends, 1);

    // R6 reserved mode gives silence
    tag = "R6"; lat = 0;
    setup(2'b10, 0, 0, 32'h0000_4000, 6, 0, 0, 2);
    launch("R6 first addr");
    for (int i = 0; i < 30; i++) begin
      tick_to(1);
      chk(smp_out == 0, "R6 silent", smp_out, 0);
    end

    // R9 R10 loop then release
    tag = "R9"; lat = 1;
    setup(2'b00, 0, 1, 32'h0000_5000, 20, 4, 10, 2);
    launch("R9 first addr");
    tick_to(300);
    chk(ends == 0, "R9 looping no end", ends, 0);
    tag = "R10";
    cfg_gate = 0;
    tick_to(120);
    chk(ends == 1, "R10 release end count", ends, 1);

    // R11 gate clear stops at once
    tag = "R11"; lat = 3;
    setup(2'b01, 0, 0, 32'h0000_6000, 200, 0, 0, 2);
    launch("R11 first addr");
    tick_to(2);
    cfg_gate = 0;
    tick_to(1);
    chk(!mem_req && smp_out == 0, "R11 stopped", {mem_req, smp_out}, 0);
    tick_to(20);
    chk(ends == 0, "R11 no end pulse", ends, 0);

    // R3 divider change mid-play, half-rate reference
    tag = "R3"; lat = 0; ref_pat = 1;
    setup(2'b00, 0, 0, 32'h0000_7000, 40, 0, 0, 8);
    launch("R3 first addr");
    tick_to(60);
    cfg_div = 3;
    tick_to(60);
    cfg_div = 0;
    tick_to(200);
    chk(ends == 1, "R3 end after divider change", ends, 1);

    // R2 restart mid-loop
    tag = "R2"; ref_pat = 0;
    setup(2'b00, 0, 1, 32'h0000_8000, 30, 2, 12, 3);
    launch("R2 first addr");
    tick_to(40);
    cfg_gate = 0;
    tick_to(1);
    launch("R2 restart addr");
    tick_to(40);

    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule